// File: doc/BRIEF.md
# Pixel Pack and Expand Unit

This unit converts 64-bit packed data between wide fixed-point lanes and 8-bit pixel bytes. An operation code chooses one of five conversions: a pack of four signed 16-bit lanes to unsigned bytes, a pack of two signed 32-bit lanes to bytes that are shifted into an existing stream of packed bytes, a pack of two signed 32-bit lanes to signed 16-bit halves, an expand of four bytes to 16-bit fixed-point lanes, and an interleave merge of two 32-bit byte streams. The packs take a left-shift amount from a scale field that is supplied alongside each request. That field comes from bits [7:3] of a graphics status word held elsewhere.

Requests enter through a valid/ready port and results leave through a valid/ready port, with one output register between them. A request accepted on a clock edge shows its result on the output on that same edge, so the result is valid one cycle after acceptance. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not accepted, the output holds its data and no new request is taken. Operation codes: 0 = 16-bit pack, 1 = 32-bit pack with shift-in, 2 = fixed pack, 3 = expand, 4 = merge, 5 to 7 = unused.

Top module: `pxu_top`

## Requirements
- R1: A request accepted when in_valid and in_ready are both high makes out_valid high in the next cycle, with the result of that request on out_data. When the output is drained and no request is taken, out_valid is low in the next cycle.
- R2: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid and out_data keep their values.
- R3: For code 0, byte i (i = 0..3) of the result is signed lane i (bits 16i+15:16i) of in_b, shifted left by in_scale[3:0], then arithmetically right by 7, then clamped to 0..255. Result bits 63:32 are zero.
- R4: For code 0, in_scale[4] has no effect on the result.
- R5: For code 1, the result is in_a shifted left by 8 with bytes 0 and 4 cleared. Byte 0 holds signed lane 0 (bits 31:0) of in_b and byte 4 holds signed lane 1 (bits 63:32), each shifted left by the full 5-bit in_scale, then arithmetically right by 23, then clamped to 0..255.
- R6: For code 2, 16-bit half i (i = 0..1) of the result is signed 32-bit lane i of in_b, shifted left by in_scale, then arithmetically right by 16, then saturated to -32768..32767. Result bits 63:32 are zero.
- R7: No bits are lost in the left shift before the clamp. For example, a 32-bit lane of 1 shifted by 31 in code 1 clamps to 255, and a lane of 0x1000 shifted by 20 in code 2 saturates to 32767.
- R8: For code 3, 16-bit lane i of the result is byte i of in_b[31:0], zero-extended and shifted left by 4.
- R9: For code 4, byte k (k = 0..3) of in_b[31:0] goes to result byte 2k, and byte k of in_a[31:0] goes to result byte 2k+1.
- R10: Codes 5, 6 and 7 give an all-zero result.
- R11: While rst_n is low, out_valid is low, and it is low in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_scale | input | 5 | Left-shift amount, bits [7:3] of the status word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result |

## Verification
Within one cycle, the output register can hand its result to the consumer while it also takes a new request. The valid and ready on both sides then depend on each other. The bench provokes this with a long run in which in_valid and out_ready are drawn at random and uneven rates, with random operation codes, operands and scales. A behavioural model predicts in_ready, out_valid and out_data for every cycle. A result replaced one cycle early, or held one cycle too long, shows up as a data or valid mismatch against that model.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int DATA_W  = 64;
  localparam int SCALE_W = 5;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pxu_op_e;
endpackage

// File: rtl/pxu_sat_lane.sv
// One lane: sign-extend, shift left, shift right arithmetically, clamp.
module pxu_sat_lane #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 8,
  parameter int POST    = 7,
  parameter int SCALE_W = 5,
  parameter int LO      = 0,
  parameter int HI      = 255
) (
  input  logic [IN_W-1:0]    din,
  input  logic [SCALE_W-1:0] shamt,
  output logic [OUT_W-1:0]   dout
);
  // wide enough that the largest left shift keeps every bit
  localparam int WW = IN_W + (1 << SCALE_W) + 1;
  localparam logic signed [WW-1:0] LO_W = WW'(LO);
  localparam logic signed [WW-1:0] HI_W = WW'(HI);

  logic signed [WW-1:0] ext, shl, shr;

  always_comb begin
    ext = {{(WW-IN_W){din[IN_W-1]}}, din};
    shl = ext <<< shamt;
    shr = shl >>> POST;
    if (shr < LO_W)      dout = OUT_W'(LO);
    else if (shr > HI_W) dout = OUT_W'(HI);
    else                 dout = shr[OUT_W-1:0];
  end
endmodule

// File: rtl/pxu_format.sv
// Combinational datapath for all five conversions.
module pxu_format
  import pxu_pkg::*;
(
  input  logic [OP_W-1:0]    op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic [SCALE_W-1:0] scale,
  output logic [DATA_W-1:0]  res
);
  localparam int N16 = DATA_W / 16;
  localparam int N32 = DATA_W / 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int NB_HALF = HALF_W / 8;

  logic [HALF_W-1:0] p16, pfx;
  logic [7:0]        p32b [N32];
  logic [DATA_W-1:0] p32, ex, mg;
  logic [SCALE_W-1:0] scale16;
  logic unused_a_top;

  assign scale16 = {1'b0, scale[SCALE_W-2:0]};
  assign unused_a_top = ^a[DATA_W-1:DATA_W-8];

  genvar i;
  generate
    for (i = 0; i < N16; i++) begin : g_l16
      pxu_sat_lane #(.IN_W(16), .OUT_W(8), .POST(7), .SCALE_W(SCALE_W),
                     .LO(0), .HI(255)) u_lane (
        .din(b[16*i +: 16]), .shamt(scale16), .dout(p16[8*i +: 8]));
    end
    for (i = 0; i < N32; i++) begin : g_l32
      pxu_sat_lane #(.IN_W(32), .OUT_W(8), .POST(23), .SCALE_W(SCALE_W),
                     .LO(0), .HI(255)) u_byte (
        .din(b[32*i +: 32]), .shamt(scale), .dout(p32b[i]));
      pxu_sat_lane #(.IN_W(32), .OUT_W(16), .POST(16), .SCALE_W(SCALE_W),
                     .LO(-32768), .HI(32767)) u_fix (
        .din(b[32*i +: 32]), .shamt(scale), .dout(pfx[16*i +: 16]));
    end
    for (i = 0; i < NB_HALF; i++) begin : g_byte
      assign ex[16*i +: 16]    = {4'b0, b[8*i +: 8], 4'b0};
      assign mg[16*i +: 8]     = b[8*i +: 8];
      assign mg[16*i + 8 +: 8] = a[8*i +: 8];
    end
  endgenerate

  always_comb begin
    p32 = {a[DATA_W-9:0], 8'h00};
    for (int k = 0; k < N32; k++) p32[32*k +: 8] = p32b[k];
  end

  always_comb begin
    case (op)
      OP_PACK16:  res = {{HALF_W{1'b0}}, p16};
      OP_PACK32:  res = p32;
      OP_PACKFIX: res = {{HALF_W{1'b0}}, pfx};
      OP_EXPAND:  res = ex;
      OP_MERGE:   res = mg;
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/pxu_top.sv
module pxu_top
  import pxu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_op,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic [SCALE_W-1:0]  in_scale,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data
);
  logic [DATA_W-1:0] fmt_res;

  pxu_format u_fmt (
    .op(in_op), .a(in_a), .b(in_b), .scale(in_scale), .res(fmt_res));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= fmt_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pxu_chk.sv
module pxu_chk
  import pxu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [OP_W-1:0]    in_op,
  input logic [DATA_W-1:0]  in_a,
  input logic [DATA_W-1:0]  in_b,
  input logic [SCALE_W-1:0] in_scale,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data
);
  logic [OP_W-1:0] held_op;
  logic unused_chk;
  assign unused_chk = ^{in_a, in_b, in_scale};

  always_ff @(posedge clk) begin
    if (!rst_n) held_op <= '0;
    else if (in_valid && in_ready) held_op <= in_op;
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_no_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3 and R6: the half-width results leave the upper word clear
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (held_op == OP_PACK16 || held_op == OP_PACKFIX)
      |-> out_data[DATA_W-1:DATA_W/2] == '0);

  p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && held_op > OP_MERGE |-> out_data == '0);

  p_reset_idle_r11: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind pxu_top pxu_chk u_chk (.*);

// File: tb/sim_pxu_top.sv
module sim_pxu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  in_op;
  logic [63:0] in_a, in_b, out_data;
  logic [4:0]  in_scale;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_valid = 1'b0;
  logic [63:0] m_data = '0;
  string       m_tag = "";

  always #4 clk = ~clk;

  pxu_top u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_scale(in_scale),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a,
                                        logic [63:0] b, logic [4:0] sc);
    logic [63:0] r;
    longint s;
    r = '0;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
        s = longint'($signed(b[16*i +: 16]));
        s = (s <<< sc[3:0]) >>> 7;
        s = clampv(s, 0, 255);
        r[8*i +: 8] = s[7:0];
      end
      3'd1: begin
        r = (a << 8) & ~64'h000000ff000000ff;
        for (int i = 0; i < 2; i++) begin
          s = longint'($signed(b[32*i +: 32]));
          s = (s <<< sc) >>> 23;
          s = clampv(s, 0, 255);
          r[32*i +: 8] = s[7:0];
        end
      end
      3'd2: for (int i = 0; i < 2; i++) begin
        s = longint'($signed(b[32*i +: 32]));
        s = (s <<< sc) >>> 16;
        s = clampv(s, -32768, 32767);
        r[16*i +: 16] = s[15:0];
      end
      3'd3: for (int i = 0; i < 4; i++) r[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
      3'd4: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]     = b[8*k +: 8];
        r[16*k + 8 +: 8] = a[8*k +: 8];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R3 pack16";
      3'd1: return "R5 pack32";
      3'd2: return "R6 fixpack";
      3'd3: return "R8 expand";
      3'd4: return "R9 merge";
      default: return "R10 unknown code";
    endcase
  endfunction

  // one cycle: check outputs against the model, drive, then advance the model
  task automatic step(bit v, logic [2:0] op, logic [63:0] a, logic [63:0] b,
                      logic [4:0] sc, bit rdy, string tg);
    bit exp_rdy;
    @(negedge clk);
    chk(out_valid == m_valid, "R1 out_valid", 64'(out_valid), 64'(m_valid));
    if (m_valid) chk(out_data == m_data, m_tag, out_data, m_data);
    in_valid = v; in_op = op; in_a = a; in_b = b; in_scale = sc; out_ready = rdy;
    #1;
    exp_rdy = !m_valid || rdy;
    chk(in_ready == exp_rdy, "R2 in_ready", 64'(in_ready), 64'(exp_rdy));
    if (v && exp_rdy) begin
      m_valid = 1'b1;
      m_data  = model(op, a, b, sc);
      m_tag   = tg;
    end else if (rdy) begin
      m_valid = 1'b0;
    end
  endtask

  task automatic one(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                     logic [4:0] sc, string tg);
    step(1'b1, op, a, b, sc, 1'b1, tg);
    step(1'b0, 3'd0, '0, '0, '0, 1'b1, tg);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
    in_scale = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 after reset", 64'(out_valid), 64'd0);

    // R3: mixed lanes: 256, -5, 0x7fff, 0x0080 with scale 3
    one(3'd0, 64'h0, 64'h0080_7fff_fffb_0100, 5'd3, "R3 pack16 clamp");
    one(3'd0, 64'hffff_ffff_ffff_ffff, 64'h1234_0040_8000_7f00, 5'd0, "R3 pack16 scale0");
    // R4: top scale bit ignored for code 0
    one(3'd0, 64'h0, 64'h0001_0010_0100_0002, 5'b10011, "R4 pack16 scale bit4");
    // R5: shift-in of previous bytes
    one(3'd1, 64'h1122_3344_5566_7788, 64'h0040_0000_ff00_0000, 5'd2, "R5 pack32 shift-in");
    // R7: left shifts that would overflow 32 bits
    one(3'd1, 64'h0, 64'h0000_0001_0000_0001, 5'd31, "R7 pack32 scale31");
    one(3'd2, 64'h0, 64'hffff_f000_0000_1000, 5'd20, "R7 fixpack wide");
    // R6: saturation both ways and pass-through
    one(3'd2, 64'h0, 64'h8000_0000_7fff_ffff, 5'd0, "R6 fixpack saturate");
    one(3'd2, 64'h0, 64'hfffe_0000_0003_4000, 5'd1, "R6 fixpack inrange");
    // R8, R9
    one(3'd3, 64'hdead_beef_0000_0000, 64'hffff_ffff_ff80_017f, 5'd7, "R8 expand");
    one(3'd4, 64'h9999_9999_a1b2_c3d4, 64'h8888_8888_0516_2738, 5'd0, "R9 merge");
    // R10: unused codes
    for (int c = 5; c < 8; c++)
      one(3'(c), 64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0, 5'd9, "R10 unknown code");

    // R2: stall with the next request waiting, then release
    step(1'b1, 3'd3, '0, 64'h0403_0201, 5'd0, 1'b0, "R2 stalled expand");
    step(1'b1, 3'd4, 64'h1, 64'h2, 5'd0, 1'b0, "R2 blocked merge");
    step(1'b1, 3'd4, 64'h1, 64'h2, 5'd0, 1'b0, "R2 blocked merge");
    step(1'b1, 3'd4, 64'h1, 64'h2, 5'd0, 1'b1, "R1 take during drain");
    step(1'b0, 3'd0, '0, '0, '0, 1'b1, "R1 drain");

    // R1 and R2: random stream, accepts and drains often in the same cycle
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step(($urandom % 4) != 0, op, {$urandom, $urandom}, {$urandom, $urandom},
           5'($urandom), ($urandom % 3) != 0, tag_of(op));
    end
    for (int n = 0; n < 3; n++) step(1'b0, 3'd0, '0, '0, '0, 1'b1, "R1 final drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule